// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small, fully associative cache of branch targets for an instruction fetch stage. Each entry pairs the word address of a branch (the PC without its two always-zero low bits) with the target that branch jumped to when it last resolved. Every cycle the fetch PC is compared against the tag of each valid entry at once. On a match the buffer raises a hit flag and drives the stored target. The next fetch address is that target when an external direction predictor also says taken. In every other case it is the fetch PC plus four.

After a branch resolves, the pipeline writes the (branch PC, target) pair through the install port.

- If the PC is already held, the install refreshes that entry's target.
- If it is not held, the install takes the lowest-numbered empty entry.
- If there is no empty entry, it takes the entry under a round-robin pointer.

A synchronous flush empties the buffer. The lookup path reads only registered state, so a lookup and an install of the same PC in one cycle see the contents from before the install.

Top module: `branch_target_cache`

## Requirements
- R1: After reset every lookup misses: `hit` is 0 and `next_pc` is `fetch_pc + 4`.
- R2: An install becomes visible one cycle after the clock edge that captures it. A later lookup of that PC gives `hit`=1 and `target` equal to the installed target, in the same cycle the PC is presented.
- R3: When `hit`=1 and `pred_taken`=1, `next_pc` equals `target`.
- R4: When `hit`=0, or `pred_taken`=0, `next_pc` is `fetch_pc + 4`, wrapping modulo 2^32 (0xFFFFFFFC gives 0x00000000).
- R5: Tags are `pc[31:2]`, so bits [1:0] of the lookup PC take no part in the match.
- R6: Installing a PC that is already held overwrites its target in place. It does not take a second entry and does not move the round-robin pointer.
- R7: A lookup in the same cycle as an install of the same PC returns the contents from before the install.
- R8: An install of a new PC fills the lowest-numbered empty entry. When all ENTRIES entries are valid, it replaces the entry under a round-robin pointer. The pointer starts at entry 0 and advances by one, wrapping, after each such replacement. With the default of 8 entries filled in order, the first two replacements evict the first and second PCs installed.
- R9: `flush` clears every valid bit and resets the pointer to entry 0 at the next edge. An install in the same cycle as a flush is dropped. Every lookup misses afterwards until a new install.
- R10: At most one entry ever matches a given lookup PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clears all entries at the next edge |
| fetch_pc | input | 32 | Fetch address to look up |
| pred_taken | input | 1 | Direction prediction for the fetched branch |
| hit | output | 1 | A valid entry matches `fetch_pc[31:2]` |
| target | output | 32 | Stored target of the matching entry (0 on a miss) |
| next_pc | output | 32 | Next fetch address |
| wr_en | input | 1 | Install request |
| wr_pc | input | 32 | Resolved branch PC to install |
| wr_target | input | 32 | Resolved target to install |

## Verification
The lookup outputs `hit`, `target` and `next_pc` are combinational from the presented PC, so each result is due in the same cycle the PC is driven. An install or flush changes what lookups see starting with the cycle after the capturing edge. The driver applies each cycle's inputs on the falling edge and queues that cycle's expected outputs. The monitor pops and compares them 2 ns later, well before the next rising edge. Same-cycle lookups of a PC that is being written therefore expect the old contents, and every check of an install or flush is placed at least one cycle after it.

// File: rtl/branch_target_cache.sv
module branch_target_cache #(
  parameter int ENTRIES = 8,
  parameter int PC_W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            pred_taken,
  output logic            hit,
  output logic [PC_W-1:0] target,
  output logic [PC_W-1:0] next_pc,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_target
);
  localparam int TAG_W = PC_W - 2;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic [ENTRIES-1:0] look_match, wr_match;
  logic [IDX_W-1:0]   wr_idx, free_idx, victim;
  logic               wr_hit, any_free;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign look_match[g] = valid_q[g] && (tag_q[g] == fetch_pc[PC_W-1:2]);
    assign wr_match[g]   = valid_q[g] && (tag_q[g] == wr_pc[PC_W-1:2]);
  end

  assign hit      = |look_match;
  assign wr_hit   = |wr_match;
  assign any_free = ~&valid_q;

  always_comb begin
    target   = '0;
    wr_idx   = '0;
    free_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_match[i]) target = target | tgt_q[i];
      if (wr_match[i])   wr_idx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) free_idx = IDX_W'(i);
  end

  assign victim  = wr_hit ? wr_idx : (any_free ? free_idx : rr_q);
  assign next_pc = (hit && pred_taken) ? target : fetch_pc + PC_W'(4);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (wr_en) begin
      valid_q[victim] <= 1'b1;
      if (!wr_hit && !any_free)
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush && wr_en) begin
      tag_q[victim] <= wr_pc[PC_W-1:2];
      tgt_q[victim] <= wr_target;
    end
  end
endmodule

// File: rtl/branch_target_cache_chk.sv
module branch_target_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int PC_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic [PC_W-1:0]    fetch_pc,
  input logic               pred_taken,
  input logic               hit,
  input logic [PC_W-1:0]    target,
  input logic [PC_W-1:0]    next_pc,
  input logic               wr_en,
  input logic [PC_W-1:0]    wr_pc,
  input logic [PC_W-1:0]    wr_target,
  input logic [ENTRIES-1:0] look_match
);
  assert_taken_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pred_taken) |-> (next_pc == target));

  assert_fallthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit || !pred_taken) |-> (next_pc == fetch_pc + PC_W'(4)));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);

  assert_install_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> ((fetch_pc[PC_W-1:2] != $past(wr_pc[PC_W-1:2])) ||
                           (hit && target == $past(wr_target))));

  assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match));
endmodule

bind branch_target_cache branch_target_cache_chk #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_pc(fetch_pc),
  .pred_taken(pred_taken), .hit(hit), .target(target), .next_pc(next_pc),
  .wr_en(wr_en), .wr_pc(wr_pc), .wr_target(wr_target), .look_match(look_match)
);

// File: tb/branch_target_cache_tb.sv
module branch_target_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_taken = 1'b0;
  logic        hit;
  logic [31:0] target, next_pc;
  logic        wr_en = 1'b0;
  logic [31:0] wr_pc = '0, wr_target = '0;

  always #5 clk = ~clk;

  branch_target_cache u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_pc(fetch_pc),
    .pred_taken(pred_taken), .hit(hit), .target(target), .next_pc(next_pc),
    .wr_en(wr_en), .wr_pc(wr_pc), .wr_target(wr_target)
  );

  typedef struct {
    logic        hit;
    logic [31:0] tgt;
    logic [31:0] nxt;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic cyc(input logic [31:0] pc, input logic tk,
                     input logic we, input logic [31:0] wpc, input logic [31:0] wtg,
                     input logic fl, input bit chk, input logic eh,
                     input logic [31:0] etg, input string req);
    exp_t e;
    @(negedge clk);
    fetch_pc = pc; pred_taken = tk; wr_en = we; wr_pc = wpc; wr_target = wtg; flush = fl;
    if (chk) begin
      e.hit = eh;
      e.tgt = eh ? etg : 32'h0;
      e.nxt = (eh && tk) ? etg : pc + 32'd4;
      e.req = req;
      q.push_back(e);
    end
  endtask

  task automatic look(input logic [31:0] pc, input logic tk, input logic eh,
                      input logic [31:0] etg, input string req);
    cyc(pc, tk, 1'b0, 32'h0, 32'h0, 1'b0, 1'b1, eh, etg, req);
  endtask

  task automatic put(input logic [31:0] wpc, input logic [31:0] wtg);
    cyc(32'h0, 1'b0, 1'b1, wpc, wtg, 1'b0, 1'b0, 1'b0, 32'h0, "");
  endtask

  always begin
    @(negedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (hit !== e.hit || target !== e.tgt || next_pc !== e.nxt) begin
        errors++;
        $display("FAIL %s: got hit=%0b target=%h next=%h, expected hit=%0b target=%h next=%h",
                 e.req, hit, target, next_pc, e.hit, e.tgt, e.nxt);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look(32'h100, 1, 0, 0, "R1 reset miss");
    look(32'hFFFFFFFC, 1, 0, 0, "R4 wrap on miss");
    put(32'h100, 32'h200);
    look(32'h100, 1, 1, 32'h200, "R2/R3 hit taken");
    look(32'h100, 0, 1, 32'h200, "R4 hit not taken");
    look(32'h102, 1, 1, 32'h200, "R5 low bits ignored");
    cyc(32'h100, 1, 1, 32'h100, 32'h300, 0, 1, 1, 32'h200, "R7 old contents");
    look(32'h100, 1, 1, 32'h300, "R6 overwrite in place");
    for (int i = 1; i < 8; i++) put(32'h1000 + 32'(i * 16), 32'h8000 + 32'(i));
    look(32'h1070, 1, 1, 32'h8007, "R8 fill last entry");
    look(32'h100, 1, 1, 32'h300, "R6 no duplicate, first kept");
    put(32'h5000, 32'h5555);
    look(32'h100, 1, 0, 0, "R8 first replacement evicts entry 0");
    look(32'h5000, 1, 1, 32'h5555, "R8 replacement installed");
    look(32'h1020, 1, 1, 32'h8002, "R8 others kept");
    put(32'h6000, 32'h6666);
    look(32'h1010, 1, 0, 0, "R8 second replacement evicts entry 1");
    put(32'h1020, 32'hABC0);
    look(32'h1020, 1, 1, 32'hABC0, "R6 refresh when full");
    put(32'h7000, 32'h7777);
    look(32'h1020, 1, 0, 0, "R6 refresh kept pointer at entry 2");
    look(32'h1030, 1, 1, 32'h8003, "R8 entry 3 kept");
    cyc(32'h0, 0, 0, 0, 0, 1, 0, 0, 0, "");
    look(32'h5000, 1, 0, 0, "R9 flush empties");
    look(32'h6000, 1, 0, 0, "R9 flush empties");
    cyc(32'h0, 0, 1, 32'h900, 32'h999, 1, 0, 0, 0, "");
    look(32'h900, 1, 0, 0, "R9 install with flush dropped");
    put(32'h900, 32'h990);
    look(32'h900, 1, 1, 32'h990, "R9/R2 install after flush");
    look(32'h904, 1, 0, 0, "R10 neighbour misses");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule